// File: doc/BRIEF.md
# Bus Cycle Break Comparator

This block watches the bus cycles that complete on a shared CPU/DMA bus. It raises a break request when one of them meets a condition that software has programmed. The condition is built from several parts:

- a break address, compared over a width that depends on the access size;
- an optional operand-size filter;
- an optional data value with a per-bit mask;
- filters on access kind (instruction fetch or data access), direction and bus master.

A single programmed address therefore catches a longword, a word or a byte access at the matching aligned address.

The condition registers are loaded through a simple write port. The bus is observed through a port that carries one completed cycle per clock in which `bus_valid` is high. A small state machine turns each qualifying cycle into a registered break pulse one clock later. It has three states:

- **OFF**: breaks are disabled.
- **WATCH**: enabled, with no pulse this cycle.
- **FIRE**: the pulse is being driven.

Its transitions are evaluated from every state:

- **disable** goes to OFF when the enable bit is clear.
- **hit** goes to FIRE when the enable bit is set and a valid cycle matches.
- **quiet** goes to WATCH when the enable bit is set and there is no match.

Top module: `bus_break_cmp`

## Requirements
- R1: After reset all condition registers are zero, `brk` is low, and no bus cycle raises `brk` until the enable bit is written.
- R2: The address comparison depends on `bus_size` (01 = byte, 10 = word, 11 = longword). A longword cycle compares bits 31..2, a word cycle compares bits 31..1, and a byte cycle compares all bits. A cycle with size 00 never matches.
- R3: The control register holds the size filter in bits 2..1 (00 any, 01 byte, 10 word, 11 longword). A non-zero value requires `bus_size` to equal it.
- R4: Control bit 9 enables the data condition. With the longword size filter, all 32 data bits are compared. A bit takes part only where the mask register bit is 0.
- R5: With the word size filter, the low 16 bits of `bus_data` are compared. With the byte size filter, the byte in `bus_data[7:0]` is copied into both bytes of a 16-bit operand. In both cases bits 31..16 of the data and mask registers, and of `bus_data`, are ignored.
- R6: When the data condition is enabled with the size filter set to any, no data cycle matches.
- R7: On an instruction fetch cycle (`bus_fetch`=1), the data and mask registers have no effect.
- R8: The kind filter is control bits 4..3 (01 fetch only, 10 data only). The direction filter is bits 6..5 (01 read only, 10 write only). The master filter is bits 8..7 (01 CPU only, 10 DMA only). The values 00 and 11 mean don't care, and every filter that is not don't care must agree.
- R9: A DMA cycle (`bus_dma`=1) never matches while the size filter is longword.
- R10: `brk` is high for exactly the one clock that follows each cycle in which `bus_valid` is high, control bit 0 (enable) is set and the condition matches. It is low otherwise.
- R11: Register writes use `wr_sel`: 0 = address, 1 = data, 2 = mask, 3 = control. A write takes effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 32 | Register write value |
| bus_valid | input | 1 | A bus cycle completes this clock |
| bus_addr | input | 32 | Cycle address |
| bus_data | input | 32 | Cycle data, operand right-justified |
| bus_size | input | 2 | Cycle operand size |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_dma | input | 1 | 1 = DMA master, 0 = CPU |
| brk | output | 1 | Registered break pulse |

## Verification
The bench aims at the narrowing of the address compare around the address 0x1003. A design that compared all 32 bits would miss the longword at 0x1000 and the word at 0x1002. A design that always masked the low bits would wrongly hit a byte at 0x1002.

It drives junk into the upper data lanes on word and byte cycles. A design that compared those lanes would drop real breaks.

It checks that a fetch ignores the data register, that a DMA longword never matches, and that a data condition with no size never matches. A design that got any of these wrong would raise a break where none is due.

Back-to-back hits, hits with the enable bit clear, and a hit followed by an idle clock expose a pulse that is late, stretched or ungated.

// File: rtl/bbk_pkg.sv
package bbk_pkg;

    typedef enum logic [1:0] {
        SZ_ANY  = 2'd0,
        SZ_BYTE = 2'd1,
        SZ_WORD = 2'd2,
        SZ_LONG = 2'd3
    } size_e;

    typedef struct packed {
        logic       den;
        logic [1:0] mst;
        logic [1:0] dir;
        logic [1:0] typ;
        size_e      size;
        logic       en;
    } ctl_t;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WATCH = 2'd1,
        ST_FIRE  = 2'd2
    } st_e;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_MASK = 2'd2;
    localparam logic [1:0] SEL_CTL  = 2'd3;

    localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/bbk_regs.sv
module bbk_regs
    import bbk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [AW-1:0] cfg_addr,
    output logic [DW-1:0] cfg_data,
    output logic [DW-1:0] cfg_mask,
    output ctl_t          cfg_ctl
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_addr <= '0;
            cfg_data <= '0;
            cfg_mask <= '0;
            cfg_ctl  <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_ADDR: cfg_addr <= wr_data[AW-1:0];
                SEL_DATA: cfg_data <= wr_data;
                SEL_MASK: cfg_mask <= wr_data;
                SEL_CTL:  cfg_ctl  <= ctl_t'(wr_data[CTL_W-1:0]);
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/bbk_match.sv
module bbk_match
    import bbk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_data,
    input  logic [DW-1:0] cfg_mask,
    input  ctl_t          cfg_ctl,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic [1:0]    bus_size,
    input  logic          bus_fetch,
    input  logic          bus_write,
    input  logic          bus_dma,
    output logic          hit
);

    localparam int LANES = DW / 8;

    logic [AW-1:0] addr_keep;
    logic          addr_ok;
    logic          size_ok;
    logic          kind_ok;
    logic          dir_ok;
    logic          mst_ok;
    logic          dma_ok;
    logic          data_ok;
    logic [DW-1:0] operand;
    logic [LANES-1:0] lane_on;
    logic [LANES-1:0] lane_bad;

    // Address: low bits dropped according to the observed access width.
    always_comb begin
        addr_keep = '1;
        addr_ok   = 1'b0;
        unique case (bus_size)
            SZ_LONG: begin addr_keep[1:0] = 2'b00; addr_ok = 1'b1; end
            SZ_WORD: begin addr_keep[0]   = 1'b0;  addr_ok = 1'b1; end
            SZ_BYTE: addr_ok = 1'b1;
            default: addr_ok = 1'b0;
        endcase
        addr_ok = addr_ok && (((bus_addr ^ cfg_addr) & addr_keep) == '0);
    end

    always_comb begin
        size_ok = (cfg_ctl.size == SZ_ANY) || (cfg_ctl.size == size_e'(bus_size));
        unique case (cfg_ctl.typ)
            2'b01:   kind_ok = bus_fetch;
            2'b10:   kind_ok = !bus_fetch;
            default: kind_ok = 1'b1;
        endcase
        unique case (cfg_ctl.dir)
            2'b01:   dir_ok = !bus_write;
            2'b10:   dir_ok = bus_write;
            default: dir_ok = 1'b1;
        endcase
        unique case (cfg_ctl.mst)
            2'b01:   mst_ok = !bus_dma;
            2'b10:   mst_ok = bus_dma;
            default: mst_ok = 1'b1;
        endcase
        dma_ok = !(bus_dma && (cfg_ctl.size == SZ_LONG));
    end

    // Operand lane build: byte is mirrored into both low lanes.
    always_comb begin
        operand = '0;
        unique case (cfg_ctl.size)
            SZ_BYTE: operand[15:0] = {bus_data[7:0], bus_data[7:0]};
            SZ_WORD: operand[15:0] = bus_data[15:0];
            default: operand       = bus_data;
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i < 2) begin : g_low
            assign lane_on[i] = 1'b1;
        end else begin : g_high
            assign lane_on[i] = (cfg_ctl.size == SZ_LONG);
        end
        assign lane_bad[i] = lane_on[i] &&
            (((operand[i*8 +: 8] ^ cfg_data[i*8 +: 8]) & ~cfg_mask[i*8 +: 8]) != 8'h00);
    end

    always_comb begin
        if (bus_fetch || !cfg_ctl.den)
            data_ok = 1'b1;
        else if (cfg_ctl.size == SZ_ANY)
            data_ok = 1'b0;
        else
            data_ok = (lane_bad == '0);
    end

    assign hit = addr_ok && size_ok && kind_ok && dir_ok && mst_ok && dma_ok && data_ok;

    a_r9_dma_never_long: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_dma) |-> (cfg_ctl.size != SZ_LONG));
    a_r6_data_needs_size: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cfg_ctl.den && !bus_fetch) |-> (cfg_ctl.size != SZ_ANY));
    a_r2_long_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_size == 2'b11) |-> (bus_addr[AW-1:2] == cfg_addr[AW-1:2]));
    a_r8_fetch_only: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cfg_ctl.typ == 2'b01) |-> bus_fetch);

endmodule

// File: rtl/bbk_fsm.sv
module bbk_fsm
    import bbk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hit_v,
    output logic brk
);

    st_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF, ST_WATCH, ST_FIRE: begin
                if (!en)       state_nx = ST_OFF;
                else if (hit_v) state_nx = ST_FIRE;
                else           state_nx = ST_WATCH;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_FIRE: brk = 1'b1;
            default: brk = 1'b0;
        endcase
    end

    a_r10_hit_gives_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hit_v) |=> brk);
    a_r10_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> $past(en && hit_v));

endmodule

// File: rtl/bus_break_cmp.sv
module bus_break_cmp
    import bbk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic [1:0]    bus_size,
    input  logic          bus_fetch,
    input  logic          bus_write,
    input  logic          bus_dma,
    output logic          brk
);

    logic [AW-1:0] cfg_addr;
    logic [DW-1:0] cfg_data;
    logic [DW-1:0] cfg_mask;
    ctl_t          cfg_ctl;
    logic          hit;

    bbk_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_mask(cfg_mask), .cfg_ctl(cfg_ctl)
    );

    bbk_match #(.AW(AW), .DW(DW)) u_match (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_mask(cfg_mask), .cfg_ctl(cfg_ctl),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_size(bus_size),
        .bus_fetch(bus_fetch), .bus_write(bus_write), .bus_dma(bus_dma), .hit(hit)
    );

    bbk_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en(cfg_ctl.en), .hit_v(hit && bus_valid), .brk(brk)
    );

endmodule

// File: tb/test_bus_break_cmp.sv
`timescale 1ns/1ps
module test_bus_break_cmp;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [1:0]  wr_sel = 0;
    logic [31:0] wr_data = 0;
    logic        bus_valid = 0;
    logic [31:0] bus_addr = 0;
    logic [31:0] bus_data = 0;
    logic [1:0]  bus_size = 0;
    logic        bus_fetch = 0;
    logic        bus_write = 0;
    logic        bus_dma = 0;
    logic        brk;

    always #4 clk = ~clk;

    bus_break_cmp i_bus_break_cmp (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data), .bus_size(bus_size),
        .bus_fetch(bus_fetch), .bus_write(bus_write), .bus_dma(bus_dma), .brk(brk)
    );

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    bit    exp_pend = 0;
    string pend_tag = "R1";

    bit [31:0] m_addr = 0, m_data = 0, m_mask = 0, m_ctl = 0;

    function automatic bit [31:0] ctl(bit en, int sz, int typ, int dir, int mst, bit den);
        return {22'd0, den, mst[1:0], dir[1:0], typ[1:0], sz[1:0], en};
    endfunction

    function automatic bit ref_hit(bit [31:0] a, bit [31:0] d, bit [1:0] sz, bit f, bit w, bit dm);
        int cs = int'(m_ctl[2:1]);
        bit [31:0] op, keep;
        case (sz)
            2'd3: if ((a >> 2) != (m_addr >> 2)) return 0;
            2'd2: if ((a >> 1) != (m_addr >> 1)) return 0;
            2'd1: if (a != m_addr) return 0;
            default: return 0;
        endcase
        if (cs != 0 && cs != int'(sz)) return 0;
        if (m_ctl[4:3] == 2'd1 && !f) return 0;
        if (m_ctl[4:3] == 2'd2 && f) return 0;
        if (m_ctl[6:5] == 2'd1 && w) return 0;
        if (m_ctl[6:5] == 2'd2 && !w) return 0;
        if (m_ctl[8:7] == 2'd1 && dm) return 0;
        if (m_ctl[8:7] == 2'd2 && !dm) return 0;
        if (dm && cs == 3) return 0;
        if (m_ctl[9] && !f) begin
            if (cs == 0) return 0;
            if (cs == 3) begin op = d; keep = ~m_mask; end
            else begin
                op = (cs == 1) ? {16'd0, d[7:0], d[7:0]} : {16'd0, d[15:0]};
                keep = ~m_mask & 32'h0000FFFF;
            end
            if (((op ^ m_data) & keep) != 0) return 0;
        end
        return 1;
    endfunction

    task automatic check(string tag, bit act, bit ex);
        checks++;
        if (act !== ex) begin
            errors++;
            $display("FAIL %s: brk actual=%0b expected=%0b at %0t", tag, act, ex, $time);
        end
    endtask

    task automatic cyc(string tag, bit v, bit [31:0] a, bit [31:0] d, bit [1:0] sz,
                       bit f, bit w, bit dm, int ex);
        bit p;
        @(negedge clk);
        check(pend_tag, brk, exp_pend);
        wr_en = 0; bus_valid = v; bus_addr = a; bus_data = d; bus_size = sz;
        bus_fetch = f; bus_write = w; bus_dma = dm;
        p = v && m_ctl[0] && ref_hit(a, d, sz, f, w, dm);
        if (ex >= 0) check({tag, " model"}, p, ex[0]);
        exp_pend = p; pend_tag = tag;
    endtask

    task automatic wr(bit [1:0] sel, bit [31:0] val);
        @(negedge clk);
        check(pend_tag, brk, exp_pend);
        wr_en = 1; wr_sel = sel; wr_data = val; bus_valid = 0;
        exp_pend = 0; pend_tag = "R11";
        case (sel)
            2'd0: m_addr = val;
            2'd1: m_data = val;
            2'd2: m_mask = val;
            default: m_ctl = val;
        endcase
    endtask

    task automatic idle(string tag);
        cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", brk, 0);
        rst_n = 1;
        // R1: disabled after reset, even an address-0 byte hit does nothing
        cyc("R1", 1, 0, 0, 1, 0, 0, 0, 0);
        idle("R1");

        // R2: address narrowing around 0x1003
        wr(0, 32'h1003); wr(3, ctl(1, 0, 0, 0, 0, 0));
        cyc("R2", 1, 32'h1000, 0, 3, 0, 0, 0, 1);
        cyc("R2", 1, 32'h1002, 0, 2, 0, 0, 0, 1);
        cyc("R2", 1, 32'h1003, 0, 1, 0, 0, 0, 1);
        cyc("R2", 1, 32'h1002, 0, 1, 0, 0, 0, 0);
        cyc("R2", 1, 32'h1000, 0, 2, 0, 0, 0, 0);
        cyc("R2", 1, 32'h1004, 0, 3, 0, 0, 0, 0);
        cyc("R2", 1, 32'h1003, 0, 0, 0, 0, 0, 0);

        // R3: size filter word
        wr(3, ctl(1, 2, 0, 0, 0, 0));
        cyc("R3", 1, 32'h1002, 0, 2, 0, 0, 0, 1);
        cyc("R3", 1, 32'h1000, 0, 3, 0, 0, 0, 0);
        cyc("R3", 1, 32'h1003, 0, 1, 0, 0, 0, 0);

        // R4: longword data with mask
        wr(0, 32'h2000); wr(1, 32'hDEADBEEF); wr(2, 32'h000000FF);
        wr(3, ctl(1, 3, 0, 0, 0, 1));
        cyc("R4", 1, 32'h2000, 32'hDEADBE00, 3, 0, 0, 0, 1);
        cyc("R4", 1, 32'h2000, 32'hDEADBFEF, 3, 0, 0, 0, 0);
        cyc("R4", 1, 32'h2004, 32'hDEADBEEF, 3, 0, 0, 0, 0);

        // R5: word and byte lanes, upper half ignored
        wr(1, 32'hAAAA1234); wr(2, 0); wr(3, ctl(1, 2, 0, 0, 0, 1));
        cyc("R5", 1, 32'h2000, 32'h00001234, 2, 0, 0, 0, 1);
        cyc("R5", 1, 32'h2000, 32'h55551234, 2, 0, 0, 0, 1);
        cyc("R5", 1, 32'h2000, 32'h00001235, 2, 0, 0, 0, 0);
        wr(0, 32'h2001); wr(1, 32'hFFFF5A5A); wr(3, ctl(1, 1, 0, 0, 0, 1));
        cyc("R5", 1, 32'h2001, 32'h0000005A, 1, 0, 0, 0, 1);
        cyc("R5", 1, 32'h2001, 32'h1234FF5A, 1, 0, 0, 0, 1);
        cyc("R5", 1, 32'h2001, 32'h0000005B, 1, 0, 0, 0, 0);

        // R6: data condition with no size never matches a data cycle
        wr(0, 32'h2000); wr(1, 0); wr(3, ctl(1, 0, 0, 0, 0, 1));
        cyc("R6", 1, 32'h2000, 0, 3, 0, 0, 0, 0);
        cyc("R6", 1, 32'h2000, 0, 2, 0, 0, 0, 0);

        // R7: fetch ignores data
        cyc("R7", 1, 32'h2000, 32'hFFFFFFFF, 3, 1, 0, 0, 1);
        wr(3, ctl(1, 3, 1, 0, 0, 1));
        cyc("R7", 1, 32'h2000, 32'h12345678, 3, 1, 0, 0, 1);

        // R8: kind, direction, master filters
        cyc("R8", 1, 32'h2000, 0, 3, 0, 0, 0, 0);
        wr(3, ctl(1, 0, 2, 2, 0, 0));
        cyc("R8", 1, 32'h2000, 0, 3, 0, 0, 0, 0);
        cyc("R8", 1, 32'h2000, 0, 3, 0, 1, 0, 1);
        cyc("R8", 1, 32'h2000, 0, 3, 1, 1, 0, 0);
        wr(3, ctl(1, 0, 3, 0, 1, 0));
        cyc("R8", 1, 32'h2000, 0, 2, 0, 0, 1, 0);
        cyc("R8", 1, 32'h2000, 0, 2, 0, 0, 0, 1);
        wr(3, ctl(1, 0, 0, 1, 2, 0));
        cyc("R8", 1, 32'h2000, 0, 2, 0, 0, 1, 1);
        cyc("R8", 1, 32'h2000, 0, 2, 0, 1, 1, 0);

        // R9: DMA vs longword size filter
        wr(0, 32'h3000); wr(3, ctl(1, 3, 0, 0, 0, 0));
        cyc("R9", 1, 32'h3000, 0, 3, 0, 0, 1, 0);
        cyc("R9", 1, 32'h3000, 0, 3, 0, 0, 0, 1);
        wr(1, 32'h0000BEEF); wr(3, ctl(1, 2, 0, 0, 0, 1));
        cyc("R9", 1, 32'h3000, 32'h0000BEEF, 2, 0, 1, 1, 1);

        // R10: enable gating and pulse shape
        wr(3, ctl(0, 0, 0, 0, 0, 0));
        cyc("R10", 1, 32'h3000, 0, 3, 0, 0, 0, 0);
        idle("R10");
        wr(3, ctl(1, 0, 0, 0, 0, 0));
        cyc("R10", 1, 32'h3000, 0, 3, 0, 0, 0, 1);
        idle("R10");
        cyc("R10", 0, 32'h3000, 0, 3, 0, 0, 0, 0);
        cyc("R10", 1, 32'h3001, 0, 1, 0, 0, 0, 0);
        cyc("R10", 1, 32'h3000, 0, 1, 0, 0, 0, 1);
        cyc("R10", 1, 32'h3002, 0, 2, 0, 0, 0, 0);
        idle("R10");

        // R11 plus mixed traffic checked against the model every clock
        for (int k = 0; k < 400; k++) begin
            if (k % 25 == 0) begin
                wr(0, 32'h4000 + ($urandom % 8));
                wr(1, $urandom); wr(2, $urandom & 32'hFF00FF0F);
                wr(3, {22'd0, 10'($urandom)} | 32'd1);
            end
            cyc("R11", ($urandom % 4) != 0, 32'h4000 + ($urandom % 8), $urandom,
                2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), -1);
        end
        idle("R11");
        idle("R11");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule